// File: doc/BRIEF.md
# TDM Signaling Stream Output Formatter

This block drives the serial signaling output of a 2.048 Mb/s TDM backplane whose frame has 32 timeslots of 8 bits each. It takes the current four-bit ABCD signaling state of 30 voice channels as a flat parallel input. A bit-clock enable and a frame pulse tell it where the line is. From these it keeps a count of the current timeslot and bit, maps each timeslot to a signaling channel, and shifts out one bit per bit period, most significant bit first.

In a timeslot that carries a channel, the low nibble holds that channel's ABCD state and the high nibble is sent as ones. Timeslots 0 and 16 carry no channel, so channels 16 to 30 sit one timeslot higher than their number. The line is modelled as a data bit plus an active-high drive enable. The enable is low in empty timeslots and whenever the global stream enable is low, so several devices can share one wire.

Top module: `sig_stream_fmt`

## Requirements
- R1: After reset, `tx_drive` and `tx_bit` are 0. `tx_drive` stays 0 until a `frame_pulse` has been seen together with `bit_tick`; bit ticks before that have no effect.
- R2: A clock edge with `bit_tick` and `frame_pulse` both high puts the output at timeslot 0, bit 7. Each later `bit_tick` moves one bit on, from bit 7 down to bit 0. After bit 0 the timeslot increments, and timeslot 31 wraps to timeslot 0.
- R3: `tx_drive` is 0 for the whole of timeslot 0 and timeslot 16.
- R4: Timeslots 17 to 31 carry channels 16 to 30. Channel n (1-based) is the 4-bit field `sig_states[4(n-1)+3 : 4(n-1)]`.
- R5: Timeslots 1 to 15 carry channels 1 to 15. In a used timeslot, slot bits 3..0 equal bits 3..0 of the channel's field, so field bit 3 goes out first within the nibble.
- R6: In a used timeslot, slot bits 7..4 go out as 1 while driven.
- R7: A channel's field is captured when its timeslot's bit 7 begins. A change to `sig_states` later in that timeslot does not alter the bits sent in it.
- R8: With `stream_en` low, `tx_drive` is 0 from the next clock edge on. Raising `stream_en` again restores driving from the next edge, with the correct bit of the current timeslot.
- R9: A `frame_pulse` with `bit_tick` at any position realigns the count to timeslot 0, bit 7.
- R10: `tx_bit` changes only on clock edges where `bit_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle enable marking each new bit period |
| frame_pulse | input | 1 | Frame alignment, sampled together with bit_tick |
| stream_en | input | 1 | Global output enable; low floats the whole stream |
| sig_states | input | NUM_CH*SIG_BITS (120) | ABCD states, channel n in bits 4(n-1)+3..4(n-1) |
| tx_bit | output | 1 | Serial data bit |
| tx_drive | output | 1 | Active-high drive enable for the line |

## Verification
Bit position, shift data and drive enable are all updated on the same edge that samples a `bit_tick`, so the new bit and its drive state are due exactly one clock after the tick is presented. A change of `stream_en` reaches `tx_drive` one clock after it is applied, with no tick needed. The bench raises each tick on a falling edge and lowers it on the next falling edge, then compares against its model at that edge, after exactly one rising edge has passed. It also compares `tx_bit` at every falling edge between ticks to confirm the bit holds. It updates its own enable copy only after one rising edge has passed since it changed `stream_en`.

// File: rtl/sig_fmt_pkg.sv
package sig_fmt_pkg;

  localparam int DEF_NUM_SLOTS = 32;
  localparam int DEF_SLOT_BITS = 8;
  localparam int DEF_SIG_BITS  = 4;
  localparam int DEF_NUM_CH    = 30;
  localparam int DEF_GAP_SLOT  = 16;

  // zero-based channel index carried by a timeslot (0 for the empty slots)
  function automatic int slot_chan(input int slot, input int gap);
    if (slot <= 0 || slot == gap) return 0;
    if (slot < gap) return slot - 1;
    return slot - 2;
  endfunction

  function automatic bit slot_used(input int slot, input int gap, input int num_ch);
    if (slot <= 0 || slot == gap) return 1'b0;
    return slot_chan(slot, gap) < num_ch;
  endfunction

endpackage

// File: rtl/sig_slot_counter.sv
module sig_slot_counter #(
  parameter int NUM_SLOTS = 32,
  parameter int SLOT_BITS = 8,
  localparam int SW = $clog2(NUM_SLOTS),
  localparam int BW = $clog2(SLOT_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_tick,
  input  logic          frame_pulse,
  output logic          synced_nxt,
  output logic [SW-1:0] slot_nxt,
  output logic          load_nxt
);

  localparam logic [BW-1:0] BIT_TOP  = BW'(SLOT_BITS - 1);
  localparam logic [SW-1:0] SLOT_TOP = SW'(NUM_SLOTS - 1);

  logic          synced_q;
  logic [SW-1:0] slot_q;
  logic [BW-1:0] bit_q;
  logic [BW-1:0] bit_nxt;

  always_comb begin
    synced_nxt = synced_q;
    slot_nxt   = slot_q;
    bit_nxt    = bit_q;
    load_nxt   = 1'b0;
    if (bit_tick) begin
      if (frame_pulse) begin
        synced_nxt = 1'b1;
        slot_nxt   = '0;
        bit_nxt    = BIT_TOP;
        load_nxt   = 1'b1;
      end else if (synced_q) begin
        if (bit_q == '0) begin
          bit_nxt  = BIT_TOP;
          slot_nxt = (slot_q == SLOT_TOP) ? '0 : slot_q + 1'b1;
          load_nxt = 1'b1;
        end else begin
          bit_nxt = bit_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      synced_q <= 1'b0;
      slot_q   <= '0;
      bit_q    <= '0;
    end else begin
      synced_q <= synced_nxt;
      slot_q   <= slot_nxt;
      bit_q    <= bit_nxt;
    end
  end

endmodule

// File: rtl/sig_chan_map.sv
module sig_chan_map #(
  parameter int NUM_SLOTS = 32,
  parameter int GAP_SLOT  = 16,
  parameter int NUM_CH    = 30,
  localparam int SW = $clog2(NUM_SLOTS),
  localparam int CW = $clog2(NUM_CH)
) (
  input  logic [SW-1:0] slot,
  output logic          used,
  output logic [CW-1:0] chan
);

  logic [NUM_SLOTS-1:0] used_tbl;
  logic [CW-1:0]        chan_tbl [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign used_tbl[g] = sig_fmt_pkg::slot_used(g, GAP_SLOT, NUM_CH);
    assign chan_tbl[g] = CW'(sig_fmt_pkg::slot_chan(g, GAP_SLOT));
  end

  assign used = used_tbl[slot];
  assign chan = chan_tbl[slot];

endmodule

// File: rtl/sig_shift_out.sv
module sig_shift_out #(
  parameter int SLOT_BITS = 8,
  parameter int SIG_BITS  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_tick,
  input  logic                load,
  input  logic                used,
  input  logic [SIG_BITS-1:0] sig_in,
  input  logic                stream_en,
  output logic                tx_bit,
  output logic                tx_drive
);

  localparam int UP = SLOT_BITS - SIG_BITS;

  logic [SLOT_BITS-1:0] sh_q, word_nxt;
  logic                 vld_q, vld_nxt, drv_q;

  always_comb begin
    vld_nxt  = vld_q;
    word_nxt = sh_q;
    if (bit_tick) begin
      if (load) begin
        vld_nxt  = used;
        word_nxt = used ? {{UP{1'b1}}, sig_in} : '0;
      end else begin
        word_nxt = {sh_q[SLOT_BITS-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      vld_q <= 1'b0;
      drv_q <= 1'b0;
    end else begin
      sh_q  <= word_nxt;
      vld_q <= vld_nxt;
      drv_q <= vld_nxt & stream_en;
    end
  end

  assign tx_bit   = sh_q[SLOT_BITS-1];
  assign tx_drive = drv_q;

endmodule

// File: rtl/sig_stream_fmt.sv
module sig_stream_fmt #(
  parameter int NUM_SLOTS = sig_fmt_pkg::DEF_NUM_SLOTS,
  parameter int SLOT_BITS = sig_fmt_pkg::DEF_SLOT_BITS,
  parameter int SIG_BITS  = sig_fmt_pkg::DEF_SIG_BITS,
  parameter int NUM_CH    = sig_fmt_pkg::DEF_NUM_CH,
  parameter int GAP_SLOT  = sig_fmt_pkg::DEF_GAP_SLOT
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bit_tick,
  input  logic                       frame_pulse,
  input  logic                       stream_en,
  input  logic [NUM_CH*SIG_BITS-1:0] sig_states,
  output logic                       tx_bit,
  output logic                       tx_drive
);

  localparam int SW = $clog2(NUM_SLOTS);
  localparam int CW = $clog2(NUM_CH);

  logic          synced_nxt;
  logic [SW-1:0] slot_nxt;
  logic          load_nxt;
  logic          used;
  logic [CW-1:0] chan;
  logic [SIG_BITS-1:0] sig_sel;

  sig_slot_counter #(
    .NUM_SLOTS(NUM_SLOTS),
    .SLOT_BITS(SLOT_BITS)
  ) cnt_i (
    .clk        (clk),
    .rst        (rst),
    .bit_tick   (bit_tick),
    .frame_pulse(frame_pulse),
    .synced_nxt (synced_nxt),
    .slot_nxt   (slot_nxt),
    .load_nxt   (load_nxt)
  );

  sig_chan_map #(
    .NUM_SLOTS(NUM_SLOTS),
    .GAP_SLOT (GAP_SLOT),
    .NUM_CH   (NUM_CH)
  ) map_i (
    .slot(slot_nxt),
    .used(used),
    .chan(chan)
  );

  always_comb begin
    sig_sel = sig_states[int'(chan)*SIG_BITS +: SIG_BITS];
  end

  sig_shift_out #(
    .SLOT_BITS(SLOT_BITS),
    .SIG_BITS (SIG_BITS)
  ) shf_i (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .load     (load_nxt & synced_nxt),
    .used     (used),
    .sig_in   (sig_sel),
    .stream_en(stream_en),
    .tx_bit   (tx_bit),
    .tx_drive (tx_drive)
  );

endmodule

// File: rtl/sig_stream_fmt_chk.sv
module sig_stream_fmt_chk #(
  parameter int NUM_SLOTS = 32,
  parameter int SLOT_BITS = 8,
  parameter int SIG_BITS  = 4,
  parameter int GAP_SLOT  = 16
) (
  input logic clk,
  input logic rst,
  input logic bit_tick,
  input logic frame_pulse,
  input logic stream_en,
  input logic tx_bit,
  input logic tx_drive
);

  localparam int TOTAL = NUM_SLOTS * SLOT_BITS;
  localparam int PW    = $clog2(TOTAL);

  logic          seen_q;
  logic [PW-1:0] pos_q;
  int            slot_c, bit_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      pos_q  <= '0;
    end else if (bit_tick) begin
      if (frame_pulse) begin
        seen_q <= 1'b1;
        pos_q  <= '0;
      end else if (seen_q) begin
        pos_q <= (int'(pos_q) == TOTAL - 1) ? '0 : pos_q + 1'b1;
      end
    end
  end

  always_comb begin
    slot_c = int'(pos_q) / SLOT_BITS;
    bit_c  = SLOT_BITS - 1 - (int'(pos_q) % SLOT_BITS);
  end

  assert_quiet_before_sync_R1: assert property (@(posedge clk) disable iff (rst)
    !seen_q |-> !tx_drive);

  assert_empty_slots_R3: assert property (@(posedge clk) disable iff (rst)
    (seen_q && (slot_c == 0 || slot_c == GAP_SLOT)) |-> !tx_drive);

  assert_upper_ones_R6: assert property (@(posedge clk) disable iff (rst)
    (seen_q && tx_drive && bit_c >= SIG_BITS) |-> tx_bit);

  assert_disable_R8: assert property (@(posedge clk) disable iff (rst)
    !stream_en |=> !tx_drive);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> $stable(tx_bit));

endmodule

bind sig_stream_fmt sig_stream_fmt_chk #(
  .NUM_SLOTS(NUM_SLOTS),
  .SLOT_BITS(SLOT_BITS),
  .SIG_BITS (SIG_BITS),
  .GAP_SLOT (GAP_SLOT)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .bit_tick   (bit_tick),
  .frame_pulse(frame_pulse),
  .stream_en  (stream_en),
  .tx_bit     (tx_bit),
  .tx_drive   (tx_drive)
);

// File: tb/sig_stream_fmt_tb.sv
module sig_stream_fmt_tb_top;

  localparam int NCH = 30;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           bit_tick = 1'b0;
  logic           frame_pulse = 1'b0;
  logic           stream_en = 1'b1;
  logic [NCH*4-1:0] sig_states = '0;
  logic           tx_bit, tx_drive;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model
  bit       m_sync = 1'b0;
  int       m_slot = 0;
  int       m_bit = 0;
  bit       m_vld = 1'b0;
  bit [7:0] m_word = '0;
  bit       m_en = 1'b1;
  bit       m_chg = 1'b0;
  bit       m_realign = 1'b0;
  logic     prev_bit;

  always #4 clk = ~clk;

  sig_stream_fmt dut_i (
    .clk        (clk),
    .rst        (rst),
    .bit_tick   (bit_tick),
    .frame_pulse(frame_pulse),
    .stream_en  (stream_en),
    .sig_states (sig_states),
    .tx_bit     (tx_bit),
    .tx_drive   (tx_drive)
  );

  function automatic bit is_used(int s);
    return s != 0 && s != 16;
  endfunction

  function automatic bit [3:0] field_of(int s, logic [NCH*4-1:0] v);
    int ch = (s < 16) ? s : s - 1;
    return v[(ch-1)*4 +: 4];
  endfunction

  function automatic string pick_tag();
    if (m_realign) return "R9";
    if (m_chg) return "R7";
    if (!m_en) return "R8";
    if (m_slot == 16) return "R3";
    if (m_slot == 0 || m_slot == 31) return "R2";
    if (m_bit >= 4) return "R6";
    if (m_slot >= 17) return "R4";
    return "R5";
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b (slot %0d bit %0d)",
               tag, what, act, exp, m_slot, m_bit);
    end
  endtask

  task automatic check_out(string tag);
    logic ed;
    ed = m_sync && m_vld && m_en;
    check(tag, "tx_drive", tx_drive, ed);
    if (ed) check(tag, "tx_bit", tx_bit, m_word[m_bit]);
    prev_bit = tx_bit;
  endtask

  task automatic do_tick(bit fp, int gaps);
    @(negedge clk);
    bit_tick = 1'b1;
    frame_pulse = fp;
    @(negedge clk);
    bit_tick = 1'b0;
    frame_pulse = 1'b0;
    if (fp) begin
      m_sync = 1'b1; m_slot = 0; m_bit = 7;
    end else if (m_sync) begin
      if (m_bit == 0) begin
        m_bit = 7;
        m_slot = (m_slot + 1) % 32;
        m_realign = 1'b0;
      end else m_bit--;
    end
    if (m_sync && m_bit == 7) begin
      m_vld = is_used(m_slot);
      m_word = m_vld ? {4'hF, field_of(m_slot, sig_states)} : 8'h00;
      m_chg = 1'b0;
    end
    check_out(pick_tag());
    for (int g = 0; g < gaps; g++) begin
      @(negedge clk);
      check("R10", "tx_bit hold", tx_bit, prev_bit);
    end
  endtask

  task automatic set_en(bit v);
    @(negedge clk);
    stream_en = v;
    @(negedge clk);
    m_en = v;
    check("R8", "tx_drive after enable change", tx_drive, m_sync && m_vld && m_en);
  endtask

  task automatic change_ch(int ch1, bit [3:0] v);
    sig_states[(ch1-1)*4 +: 4] = v;
    if (m_sync && m_bit != 0 && m_vld) m_chg = 1'b1;
  endtask

  task automatic rand_step();
    if ($urandom_range(7) == 0) change_ch($urandom_range(30, 1), 4'($urandom));
    if ($urandom_range(63) == 0) set_en(~m_en);
    do_tick(1'b0, $urandom_range(2, 0));
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int c = 1; c <= NCH; c++) sig_states[(c-1)*4 +: 4] = 4'($urandom);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "tx_drive after reset", tx_drive, 1'b0);
    check("R1", "tx_bit after reset", tx_bit, 1'b0);
    // ticks before any frame pulse
    for (int i = 0; i < 12; i++) begin
      do_tick(1'b0, 1);
      check("R1", "no drive before sync", tx_drive, 1'b0);
    end
    // align and run random frames
    do_tick(1'b1, 1);
    for (int i = 0; i < 600; i++) rand_step();
    if (!m_en) set_en(1'b1);
    // directed: walk to slot 5 bit 6, change its channel mid-slot
    while (!(m_slot == 5 && m_bit == 6)) do_tick(1'b0, 0);
    change_ch(5, ~field_of(5, sig_states));
    while (!(m_slot == 6 && m_bit == 7)) do_tick(1'b0, 1);
    // directed: disable mid-slot then re-enable mid-slot
    while (!(m_slot == 20 && m_bit == 5)) do_tick(1'b0, 0);
    set_en(1'b0);
    do_tick(1'b0, 0);
    do_tick(1'b0, 0);
    set_en(1'b1);
    do_tick(1'b0, 0);
    // directed: realign mid-frame at slot 23 bit 3
    while (!(m_slot == 23 && m_bit == 3)) do_tick(1'b0, 0);
    m_realign = 1'b1;
    do_tick(1'b1, 0);
    for (int i = 0; i < 300; i++) rand_step();
    // directed: all-ones and all-zeros fields across the wrap
    sig_states = '0;
    for (int i = 0; i < 260; i++) do_tick(1'b0, 0);
    sig_states = '1;
    for (int i = 0; i < 260; i++) do_tick(1'b0, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule